// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the master side of a three-wire link to a 16-bit successive-approximation converter. The three wires are an active-low select, a serial clock that the block drives, and a returning data line. A single-cycle `start` opens a frame. The block lowers the select line and waits a short setup time. It then produces a fixed number of serial clocks, made by dividing the system clock.

The first clocks of a frame let the converter finish its conversion, and the data line carries nothing useful during them. One guard bit, which must be zero, comes next. After it come the sixteen result bits, most significant first. Any clocks left over after the last data bit are ignored.

When the last clock has fallen, the block raises the select line again. It presents the captured word with a one-cycle valid strobe and a framing flag. It also holds the select line high long enough for the converter to reacquire its input. A `start` that arrives too early is kept pending until both the minimum frame spacing and the acquisition time have passed.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0, `result_valid` is 0, `result` is 0 and `framing_error` is 0. Asserting reset in the middle of a frame returns the outputs to these values.
- R2: After `adc_cs_n` falls, `adc_sclk` stays low for at least SETUP_CYC system cycles before its first rising edge.
- R3: Every frame contains exactly FRAME_CLKS (default 24) rising edges of `adc_sclk` while `adc_cs_n` is low. `adc_sclk` is never high while `adc_cs_n` is high.
- R4: Within a frame, every high phase of `adc_sclk` lasts exactly HALF_DIV system cycles, and so does every low phase between two rising edges.
- R5: Rising edges are numbered from 1 within a frame. `result` holds the bits sampled at rising edges CONV_CLKS+2 through CONV_CLKS+17, with the first of them at bit 15. What the data line shows at rising edges 1 through CONV_CLKS, and after edge CONV_CLKS+17, has no effect on the result.
- R6: `framing_error` is 1 exactly when the bit sampled at rising edge CONV_CLKS+1 is 1. It is updated together with `result` at the end of each frame.
- R7: `result_valid` is high for exactly one cycle per frame. `adc_cs_n` is still low in that cycle and is high in the next one.
- R8: Two successive falling edges of `adc_cs_n` are at least PERIOD_CYC system cycles apart. `busy` is high from the cycle after an accepted `start` until the block is idle again. A `start` that arrives while `busy` is high is not lost: it opens the next frame once the spacing allows.
- R9: Between frames, `adc_cs_n` stays high for at least ACQ_CYC system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request for one frame |
| busy | output | 1 | A frame or the recovery after it is in progress |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| result | output | 16 | Last captured conversion word |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| framing_error | output | 1 | Guard bit of the last frame was not zero |

## Verification
The hardest case to reach from the ports is a `start` that arrives while the block is still finishing the previous frame or waiting out its recovery. If the pending request were dropped, or served too early, no single frame would show it. The bench therefore issues the next `start` as soon as the previous result has been strobed, and it also issues one in the middle of a frame. It measures the spacing between successive select falls and the high time of the select line against the limits. A converter model drives ones during the conversion clocks and the trailing clocks, and it sets the guard bit on some frames. A result that picks up the wrong clock slots therefore differs from the expected word.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_SHIFT,
    ST_TRAIL,
    ST_RECOVER
  } frame_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen
  import adc_frame_pkg::*;
#(
  parameter int unsigned HALF_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int unsigned CW = cnt_w(HALF_DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d  = '0;
    sclk_d = 1'b0;
    if (run) begin
      if (wrap) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        sclk_d = sclk_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign rise_tick = run & wrap & ~sclk_q;
  assign fall_tick = run & wrap & sclk_q;
  assign sclk      = sclk_q;

  assert_stopped_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !sclk_q);

endmodule

// File: rtl/adc_rate_limiter.sv
module adc_rate_limiter
  import adc_frame_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int unsigned PW = cnt_w(PERIOD_CYC);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = PW'(PERIOD_CYC - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  assert_load_after_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture
  import adc_frame_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              zero_en,
  input  logic              shift_en,
  input  logic              commit,
  input  logic              sdi,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              framing_error
);

  localparam int unsigned SCW = cnt_w(DATA_W);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              guard_q, guard_d;
  logic [DATA_W-1:0] res_q;
  logic              err_q, vld_q;
  logic [SCW-1:0]    nshift_q;

  always_comb begin
    shreg_d = shreg_q;
    guard_d = guard_q;
    if (clear) begin
      shreg_d = '0;
      guard_d = 1'b0;
    end else begin
      if (zero_en)  guard_d = sdi;
      if (shift_en) shreg_d = {shreg_q[DATA_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      guard_q <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      guard_q <= guard_d;
      vld_q   <= commit;
      if (commit) begin
        res_q <= shreg_q;
        err_q <= guard_q;
      end
    end
  end

  assign result        = res_q;
  assign result_valid  = vld_q;
  assign framing_error = err_q;

  // bit counter kept for checking only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nshift_q <= '0;
    else if (clear)    nshift_q <= '0;
    else if (shift_en) nshift_q <= nshift_q + 1'b1;
  end

  assert_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (nshift_q == SCW'(DATA_W)));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FRAME_CLKS = 24,
  parameter int unsigned CONV_CLKS  = 5,
  parameter int unsigned SETUP_CYC  = 6,
  parameter int unsigned ACQ_CYC    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rise_tick,
  input  logic fall_tick,
  input  logic period_done,
  output logic run,
  output logic cs_n,
  output logic busy,
  output logic frame_load,
  output logic zero_en,
  output logic shift_en,
  output logic commit
);

  localparam int unsigned LAST_DATA = CONV_CLKS + 1 + DATA_W;
  localparam int unsigned EW        = cnt_w(FRAME_CLKS);
  localparam int unsigned WAIT_MAX  = (SETUP_CYC > ACQ_CYC) ? SETUP_CYC : ACQ_CYC;
  localparam int unsigned TW        = cnt_w(WAIT_MAX);

  frame_state_e  state_q, state_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          cs_n_q;
  logic          in_frame;

  always_comb begin
    state_d    = state_q;
    edge_d     = edge_q;
    tmr_d      = tmr_q;
    pend_d     = pend_q | start;
    frame_load = 1'b0;
    commit     = 1'b0;
    if (rise_tick) edge_d = edge_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if ((start || pend_q) && period_done) begin
          state_d    = ST_SETUP;
          tmr_d      = '0;
          edge_d     = '0;
          pend_d     = 1'b0;
          frame_load = 1'b1;
        end
      end
      ST_SETUP: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TW'(SETUP_CYC - 1)) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (fall_tick && edge_q == EW'(CONV_CLKS)) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (fall_tick && edge_q == EW'(LAST_DATA)) begin
          if (LAST_DATA >= FRAME_CLKS) begin
            state_d = ST_RECOVER;
            tmr_d   = '0;
            commit  = 1'b1;
          end else begin
            state_d = ST_TRAIL;
          end
        end
      end
      ST_TRAIL: begin
        if (fall_tick && edge_q == EW'(FRAME_CLKS)) begin
          state_d = ST_RECOVER;
          tmr_d   = '0;
          commit  = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (tmr_q != TW'(ACQ_CYC)) tmr_d = tmr_q + 1'b1;
        if (tmr_q == TW'(ACQ_CYC) && period_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign in_frame = (state_q == ST_SETUP) || (state_q == ST_CONV) ||
                    (state_q == ST_SHIFT) || (state_q == ST_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      tmr_q   <= '0;
      pend_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      tmr_q   <= tmr_d;
      pend_q  <= pend_d;
      cs_n_q  <= ~in_frame;
    end
  end

  assign run      = (state_q == ST_CONV) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
  assign cs_n     = cs_n_q;
  assign busy     = (state_q != ST_IDLE);
  assign zero_en  = rise_tick && (state_q == ST_SHIFT) && (edge_q == EW'(CONV_CLKS));
  assign shift_en = rise_tick && (state_q == ST_SHIFT) && (edge_q != EW'(CONV_CLKS));

  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= EW'(FRAME_CLKS));

  assert_commit_after_all_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (edge_q == EW'(FRAME_CLKS)) && !rise_tick);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FRAME_CLKS = 24,
  parameter int unsigned CONV_CLKS  = 5,
  parameter int unsigned HALF_DIV   = 16,
  parameter int unsigned SETUP_CYC  = 6,
  parameter int unsigned ACQ_CYC    = 100,
  parameter int unsigned PERIOD_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdo,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              framing_error
);

  localparam int unsigned HW = cnt_w(ACQ_CYC);

  logic run, rise_tick, fall_tick, period_done;
  logic frame_load, zero_en, shift_en, commit;

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sclk      (adc_sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_rate_limiter #(.PERIOD_CYC(PERIOD_CYC)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_load),
    .done  (period_done)
  );

  adc_frame_seq #(
    .DATA_W     (DATA_W),
    .FRAME_CLKS (FRAME_CLKS),
    .CONV_CLKS  (CONV_CLKS),
    .SETUP_CYC  (SETUP_CYC),
    .ACQ_CYC    (ACQ_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .period_done (period_done),
    .run         (run),
    .cs_n        (adc_cs_n),
    .busy        (busy),
    .frame_load  (frame_load),
    .zero_en     (zero_en),
    .shift_en    (shift_en),
    .commit      (commit)
  );

  adc_bit_capture #(.DATA_W(DATA_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (frame_load),
    .zero_en       (zero_en),
    .shift_en      (shift_en),
    .commit        (commit),
    .sdi           (adc_sdo),
    .result        (result),
    .result_valid  (result_valid),
    .framing_error (framing_error)
  );

  // select-high duration, kept for checking only
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               hi_cnt_q <= HW'(ACQ_CYC);
    else if (!adc_cs_n)                       hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(ACQ_CYC))        hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_sclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  assert_select_before_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !adc_sclk);

  assert_acq_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(hi_cnt_q) == HW'(ACQ_CYC));

  assert_valid_before_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !adc_cs_n ##1 adc_cs_n);

endmodule

// File: tb/adc_frame_ctrl_bench.sv
module adc_frame_ctrl_bench;

  localparam int DATA_W = 16;
  localparam int FRAME  = 24;
  localparam int CONV   = 5;
  localparam int HALF   = 16;
  localparam int SETUP  = 6;
  localparam int ACQ    = 100;
  localparam int PERIOD = 2500;
  localparam int NVEC   = 8;

  // {word[17:2], guard bit driven[1], expected framing flag[0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {16'hA5C3, 1'b0, 1'b0},
    {16'h0000, 1'b0, 1'b0},
    {16'hFFFF, 1'b0, 1'b0},
    {16'h8001, 1'b0, 1'b0},
    {16'h7FFE, 1'b1, 1'b1},
    {16'h1234, 1'b0, 1'b0},
    {16'hFFFF, 1'b1, 1'b1},
    {16'h5A5A, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic adc_sdo = 1'b1;
  logic busy, adc_cs_n, adc_sclk, result_valid, framing_error;
  logic [DATA_W-1:0] result;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  adc_frame_ctrl u_adc_frame_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .adc_cs_n      (adc_cs_n),
    .adc_sclk      (adc_sclk),
    .adc_sdo       (adc_sdo),
    .result        (result),
    .result_valid  (result_valid),
    .framing_error (framing_error)
  );

  // converter model: updates its output after each falling serial clock
  logic [DATA_W-1:0] m_word = '0;
  logic              m_guard = 1'b0;
  int                nfall = 0;

  always @(negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      nfall = 0;
      adc_sdo = 1'b1;
    end else begin
      nfall = nfall + 1;
      if (nfall == CONV)
        adc_sdo = m_guard;
      else if (nfall > CONV && nfall <= CONV + DATA_W)
        adc_sdo = m_word[DATA_W-1-(nfall-CONV-1)];
      else
        adc_sdo = 1'b1;
    end
  end

  // port monitors, sampled on the falling system clock
  logic cs_p = 1'b1, sck_p = 1'b0, vld_p = 1'b0;
  int cyc = 0, rises = 0, since_fall = 0, phase_len = 0, cs_hi_len = 0, last_fall = 0;
  int have_frame = 0, bad_setup = 0, bad_phase = 0, bad_idle = 0;
  int bad_gap = 0, bad_period = 0, bad_valid = 0, valid_cnt = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (adc_cs_n && adc_sclk) bad_idle = bad_idle + 1;
      if (cs_p && !adc_cs_n) begin
        if (have_frame != 0) begin
          if (cs_hi_len < ACQ) bad_gap = bad_gap + 1;
          if (cyc - last_fall < PERIOD) bad_period = bad_period + 1;
        end
        have_frame = 1;
        last_fall  = cyc;
        rises      = 0;
        since_fall = 0;
      end
      if (!cs_p && adc_cs_n) cs_hi_len = 0;
      if (adc_cs_n) cs_hi_len = cs_hi_len + 1;
      else          since_fall = since_fall + 1;
      if (adc_sclk != sck_p) begin
        if (adc_sclk) begin
          rises = rises + 1;
          if (rises == 1) begin
            if (since_fall <= SETUP) bad_setup = bad_setup + 1;
          end else if (phase_len != HALF) bad_phase = bad_phase + 1;
        end else if (phase_len != HALF) bad_phase = bad_phase + 1;
        phase_len = 1;
      end else phase_len = phase_len + 1;
      if (result_valid) begin
        valid_cnt = valid_cnt + 1;
        if (vld_p || adc_cs_n) bad_valid = bad_valid + 1;
      end
      if (vld_p && !adc_cs_n) bad_valid = bad_valid + 1;
    end
    cs_p  = adc_cs_n;
    sck_p = adc_sclk;
    vld_p = result_valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!result_valid);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail = nfail + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int frames;
    frames = 0;
    repeat (4) @(negedge clk);
    // R1: values while reset is held
    chk("R1 cs_n in reset", 32'(adc_cs_n), 32'd1);
    chk("R1 sclk in reset", 32'(adc_sclk), 32'd0);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 32'(result_valid), 32'd0);
    chk("R1 result after reset", 32'(result), 32'd0);
    chk("R1 error after reset", 32'(framing_error), 32'd0);

    // vector walk; each start after the first lands while busy (R8 hold)
    for (int i = 0; i < NVEC; i++) begin
      m_word  = VEC[i][17:2];
      m_guard = VEC[i][1];
      pulse_start();
      wait_valid();
      frames = frames + 1;
      chk($sformatf("R5 word vec %0d", i), 32'(result), 32'(VEC[i][17:2]));
      chk($sformatf("R6 guard flag vec %0d", i), 32'(framing_error), 32'(VEC[i][0]));
      chk($sformatf("R3 clock count vec %0d", i), 32'(rises), 32'(FRAME));
    end

    // R8: a start issued in the middle of a frame is held, then served
    wait (!busy);
    @(negedge clk);
    chk("R8 idle busy low", 32'(busy), 32'd0);
    m_word = 16'hC0DE; m_guard = 1'b0;
    pulse_start();
    chk("R8 busy after start", 32'(busy), 32'd1);
    repeat (200) @(negedge clk);
    pulse_start();
    wait_valid();
    frames = frames + 1;
    chk("R5 word before held frame", 32'(result), 32'h0000C0DE);
    @(negedge clk);
    m_word = 16'h0F0F;
    wait_valid();
    frames = frames + 1;
    chk("R8 held start produced frame", 32'(result), 32'h00000F0F);
    chk("R6 clean guard after held frame", 32'(framing_error), 32'd0);
    wait (!busy);
    repeat (PERIOD + 50) @(negedge clk);
    chk("R8 no spurious frame", 32'(valid_cnt), 32'(frames));

    // aggregated port measurements
    chk("R2 setup before first clock", 32'(bad_setup), 32'd0);
    chk("R3 clock while deselected", 32'(bad_idle), 32'd0);
    chk("R4 phase lengths", 32'(bad_phase), 32'd0);
    chk("R7 strobe shape", 32'(bad_valid), 32'd0);
    chk("R8 frame spacing", 32'(bad_period), 32'd0);
    chk("R9 acquisition gap", 32'(bad_gap), 32'd0);

    // R1: reset in the middle of a frame
    pulse_start();
    repeat (300) @(negedge clk);
    chk("R1 frame active before reset", 32'(adc_cs_n), 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after mid-frame reset", 32'(adc_cs_n), 32'd1);
    chk("R1 sclk after mid-frame reset", 32'(adc_sclk), 32'd0);
    chk("R1 busy after mid-frame reset", 32'(busy), 32'd0);
    chk("R1 result after mid-frame reset", 32'(result), 32'd0);
    finish_run();
  end

endmodule